// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the arithmetic and logic unit of a small RISC-style core. Each accepted request carries two byte operands, an incoming carry, the current zero flag and an operation code. One clock edge later the block presents a registered result and six status flags. Alongside the flags it gives a matching set of write enables. These tell an outside status register which of its flags this operation is allowed to change. Register-file access, instruction decode, multiply and branching stay outside.

The byte operations cover add and subtract with and without carry, AND/OR/XOR, one's and two's complement, increment, decrement, three right shifts and a nibble swap. A word mode adds or subtracts a small unsigned immediate to a 16-bit register pair (low byte on `op_a`, high byte on `op_b`). It reuses the byte adder over two cycles. While it runs, `busy` is high and new requests are not taken.

Top module: `byte_alu`

## Requirements
- R1: Operation codes on `op`: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 AND, 5 OR, 6 XOR, 7 one's complement, 8 negate, 9 increment, 10 decrement, 11 logical shift right, 12 rotate right through carry, 13 arithmetic shift right, 14 nibble swap, 15 word add immediate, 16 word subtract immediate. For a byte operation (codes 0 to 14) accepted at a clock edge, `out_valid` is high for the one cycle that follows that edge.
- R2: Codes 0 to 3 give the byte sum or difference, with the carry-in used only by codes 1 and 3. They update H, S, V, N, Z and C. C is the carry out of bit 7 (the borrow for subtract), H is the carry or borrow out of bit 3, V is signed overflow, N is bit 7 of the result and Z marks a zero result.
- R3: For subtract with carry, Z is set only when the result is zero and `zero_in` is 1, so a zero flag can only be kept or cleared across a multi-byte chain.
- R4: AND, OR and XOR update S, V, N and Z only. They clear V and never update C.
- R5: Increment and decrement update S, V, N and Z, never C. V is set when increment yields 0x80 or decrement yields 0x7F.
- R6: One's complement yields 0xFF minus `op_a`, forces C to 1 and clears V, and does not update H. Negate yields 0x00 minus `op_a` and updates all six flags. C is set for any nonzero result and H is the borrow out of bit 3.
- R7: Logical shift right puts 0 into bit 7. Rotate right puts `carry_in` into bit 7. Arithmetic shift right keeps bit 7. In all three, C takes the old bit 0, V equals N XOR C, and S, V, N, Z and C are updated.
- R8: Nibble swap exchanges bits 7:4 with bits 3:0 and its flag enables are all zero.
- R9: Whenever S is updated, it equals N XOR V.
- R10: A word operation accepted at one edge raises `busy` for one cycle and completes at the next edge. `out_valid` then gives the 16-bit result on `result_hi`:`result`, with S, V, N, Z and C updated. Add sets C on 16-bit carry out and subtract sets it on borrow. V is 16-bit signed overflow, N is bit 15 and Z marks a zero word.
- R11: A request presented while `busy` is high is ignored. It produces no `out_valid` pulse and does not change the word result.
- R12: `flags` and `flag_we` use bit 5 H, bit 4 S, bit 3 V, bit 2 N, bit 1 Z, bit 0 C. `flag_we` is zero whenever `out_valid` is low. After reset, `out_valid`, `busy`, `flag_we`, `result` and `result_hi` are zero. For byte operations `result_hi` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, taken when `busy` is low |
| op | input | 5 | Operation code |
| op_a | input | 8 | First operand; low byte of the pair in word mode |
| op_b | input | 8 | Second operand; high byte of the pair in word mode |
| imm | input | 6 | Unsigned immediate for word mode |
| carry_in | input | 1 | Current carry flag |
| zero_in | input | 1 | Current zero flag |
| busy | output | 1 | Word operation in its second cycle |
| out_valid | output | 1 | Result and flags valid this cycle |
| result | output | 8 | Byte result, or low byte of the word result |
| result_hi | output | 8 | High byte of the word result, zero otherwise |
| flags | output | 6 | Computed status flags |
| flag_we | output | 6 | Per-flag update enables |

## Verification
A wrong flag or a wrong enable mask is visible at the ports on the very cycle `out_valid` rises, one edge after the request. The bench therefore compares every operation against a behavioural model over all first-operand values. Wrong word-mode state, such as a lost inter-byte carry or a stale high byte, shows only on the second edge, in `result_hi` and in the C, V and Z flags. The word sweep targets the 0xFFFF, 0x0000, 0x7FFF and 0x8000 boundaries for that reason. A busy flag that clears too early shows up as an extra `out_valid` pulse in the cycle after a word result.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_COM  = 5'd7,
    OP_NEG  = 5'd8,
    OP_INC  = 5'd9,
    OP_DEC  = 5'd10,
    OP_LSR  = 5'd11,
    OP_ROR  = 5'd12,
    OP_ASR  = 5'd13,
    OP_SWAP = 5'd14,
    OP_WADD = 5'd15,
    OP_WSUB = 5'd16
  } alu_op_e;

  localparam int NFLAGS = 6;
  localparam int FLG_C  = 0;
  localparam int FLG_Z  = 1;
  localparam int FLG_N  = 2;
  localparam int FLG_V  = 3;
  localparam int FLG_S  = 4;
  localparam int FLG_H  = 5;

  typedef logic [NFLAGS-1:0] flag_vec_t;

  // enable masks: everything / no carry, no half / no half
  localparam flag_vec_t WE_ALL = 6'b111111;
  localparam flag_vec_t WE_SVNZ = 6'b011110;
  localparam flag_vec_t WE_SVNZC = 6'b011111;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         half,
  output logic         ovf
);
  logic [W-1:0]  b_eff;
  logic          c_eff;
  logic [W:0]    full;
  logic [NIB:0]  low;

  // subtract as a + ~b + ~borrow; carry outputs inverted to read as borrow
  assign b_eff = sub ? ~b : b;
  assign c_eff = sub ? ~cin : cin;
  assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
  assign low   = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
  assign sum   = full[W-1:0];
  assign cout  = full[W] ^ sub;
  assign half  = low[NIB] ^ sub;
  assign ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam int HALF = W / 2;

  always_comb begin
    res  = '0;
    cout = 1'b0;
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_COM:  begin res = ~a; cout = 1'b1; end
      OP_LSR:  begin res = {1'b0, a[W-1:1]};   cout = a[0]; end
      OP_ROR:  begin res = {cin, a[W-1:1]};    cout = a[0]; end
      OP_ASR:  begin res = {a[W-1], a[W-1:1]}; cout = a[0]; end
      OP_SWAP: res = {a[HALF-1:0], a[W-1:HALF]};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int W     = 8,
  parameter int IMM_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [4:0]        op,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              carry_in,
  input  logic              zero_in,
  output logic              busy,
  output logic              out_valid,
  output logic [W-1:0]      result,
  output logic [W-1:0]      result_hi,
  output logic [NFLAGS-1:0] flags,
  output logic [NFLAGS-1:0] flag_we
);
  alu_op_e  opc;
  logic     accept, is_word;
  logic     busy_q, wsub_q, carry_q;
  logic [W-1:0] lo_q, hi_q;

  assign opc     = alu_op_e'(op);
  assign accept  = in_valid && !busy_q;
  assign is_word = (opc == OP_WADD) || (opc == OP_WSUB);
  assign busy    = busy_q;

  // shared adder: byte ops, word low byte, then word high byte with held carry
  logic [W-1:0] ar_a, ar_b, ar_sum;
  logic         ar_c, ar_sub, ar_cout, ar_half, ar_ovf;

  always_comb begin
    ar_a = op_a;  ar_b = op_b;  ar_c = 1'b0;  ar_sub = 1'b0;
    if (busy_q) begin
      ar_a = hi_q;  ar_b = '0;  ar_c = carry_q;  ar_sub = wsub_q;
    end else begin
      case (opc)
        OP_ADC:  ar_c = carry_in;
        OP_SUB:  ar_sub = 1'b1;
        OP_SBC:  begin ar_sub = 1'b1; ar_c = carry_in; end
        OP_NEG:  begin ar_a = '0; ar_b = op_a; ar_sub = 1'b1; end
        OP_INC:  ar_b = W'(1);
        OP_DEC:  begin ar_b = W'(1); ar_sub = 1'b1; end
        OP_WADD: ar_b = W'(imm);
        OP_WSUB: begin ar_b = W'(imm); ar_sub = 1'b1; end
        default: ;
      endcase
    end
  end

  alu_addsub #(.W(W)) u_addsub (
    .a(ar_a), .b(ar_b), .cin(ar_c), .sub(ar_sub),
    .sum(ar_sum), .cout(ar_cout), .half(ar_half), .ovf(ar_ovf)
  );

  logic [W-1:0] bt_res;
  logic         bt_cout;

  alu_bitops #(.W(W)) u_bitops (
    .op(opc), .a(op_a), .b(op_b), .cin(carry_in), .res(bt_res), .cout(bt_cout)
  );

  // byte result and flag selection
  logic [W-1:0] r_n;
  flag_vec_t    f_n, we_n;
  logic         c_b, v_b, h_b, n_b, z_b;

  always_comb begin
    r_n = bt_res;  c_b = bt_cout;  v_b = 1'b0;  h_b = 1'b0;  we_n = '0;
    case (opc)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
        r_n = ar_sum; c_b = ar_cout; h_b = ar_half; v_b = ar_ovf; we_n = WE_ALL;
      end
      OP_INC, OP_DEC: begin r_n = ar_sum; v_b = ar_ovf; we_n = WE_SVNZ; end
      OP_AND, OP_OR, OP_XOR: we_n = WE_SVNZ;
      OP_COM: we_n = WE_SVNZC;
      OP_LSR, OP_ROR, OP_ASR: begin v_b = bt_res[W-1] ^ bt_cout; we_n = WE_SVNZC; end
      default: we_n = '0;
    endcase
    n_b = r_n[W-1];
    z_b = (r_n == '0) && ((opc != OP_SBC) || zero_in);
    f_n = '0;
    f_n[FLG_C] = c_b;
    f_n[FLG_Z] = z_b;
    f_n[FLG_N] = n_b;
    f_n[FLG_V] = v_b;
    f_n[FLG_S] = n_b ^ v_b;
    f_n[FLG_H] = h_b;
  end

  // word completion flags from the high-byte pass
  flag_vec_t wf;
  logic      w_n, w_v, w_c;

  always_comb begin
    w_n = ar_sum[W-1];
    w_v = wsub_q ? (hi_q[W-1] & ~w_n) : (~hi_q[W-1] & w_n);
    w_c = wsub_q ? (w_n & ~hi_q[W-1]) : (hi_q[W-1] & ~w_n);
    wf = '0;
    wf[FLG_C] = w_c;
    wf[FLG_Z] = (ar_sum == '0) && (lo_q == '0);
    wf[FLG_N] = w_n;
    wf[FLG_V] = w_v;
    wf[FLG_S] = w_n ^ w_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      wsub_q    <= 1'b0;
      carry_q   <= 1'b0;
      lo_q      <= '0;
      hi_q      <= '0;
      out_valid <= 1'b0;
      result    <= '0;
      result_hi <= '0;
      flags     <= '0;
      flag_we   <= '0;
    end else if (busy_q) begin
      busy_q    <= 1'b0;
      out_valid <= 1'b1;
      result    <= lo_q;
      result_hi <= ar_sum;
      flags     <= wf;
      flag_we   <= WE_SVNZC;
    end else if (accept && is_word) begin
      busy_q    <= 1'b1;
      wsub_q    <= (opc == OP_WSUB);
      carry_q   <= ar_cout;
      lo_q      <= ar_sum;
      hi_q      <= op_b;
      out_valid <= 1'b0;
      flag_we   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      result    <= r_n;
      result_hi <= '0;
      flags     <= f_n;
      flag_we   <= we_n;
    end else begin
      out_valid <= 1'b0;
      flag_we   <= '0;
    end
  end

  AST_BYTE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    accept && !is_word |=> out_valid);  // R1
  AST_WORD_START: assert property (@(posedge clk) disable iff (rst)
    accept && is_word |=> busy && !out_valid);  // R10
  AST_WORD_FINISH: assert property (@(posedge clk) disable iff (rst)
    busy |=> out_valid && !busy);  // R11
  AST_SWAP_QUIET: assert property (@(posedge clk) disable iff (rst)
    accept && opc == OP_SWAP |=> flag_we == '0);  // R8
  AST_CARRY_KEPT: assert property (@(posedge clk) disable iff (rst)
    accept && (opc inside {OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC}) |=> !flag_we[FLG_C]);  // R5
  AST_COM_CARRY: assert property (@(posedge clk) disable iff (rst)
    accept && opc == OP_COM |=> flags[FLG_C] && flag_we[FLG_C]);  // R6
  AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> flag_we == '0);  // R12
endmodule

// File: tb/byte_alu_tb.sv
module byte_alu_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [4:0] op;
  logic [7:0] op_a, op_b;
  logic [5:0] imm;
  logic       carry_in, zero_in;
  logic       busy, out_valid;
  logic [7:0] result, result_hi;
  logic [5:0] flags, flag_we;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  byte_alu u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .op_a(op_a), .op_b(op_b),
    .imm(imm), .carry_in(carry_in), .zero_in(zero_in), .busy(busy),
    .out_valid(out_valid), .result(result), .result_hi(result_hi),
    .flags(flags), .flag_we(flag_we)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      if (fails <= 30) $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int sgn8(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic string req_of(input int o);
    case (o)
      0, 1, 2:    return "R2";
      3:          return "R3";
      4, 5, 6:    return "R4";
      7, 8:       return "R6";
      9, 10:      return "R5";
      11, 12, 13: return "R7";
      default:    return "R8";
    endcase
  endfunction

  // returns {we, flags masked by we, result}; flag bits C0 Z1 N2 V3 S4 H5
  function automatic logic [19:0] model(input int o, input int a, input int b, input int c, input int z);
    int r, t, x, y, cc, sv;
    logic [5:0] f, we;
    f = '0; we = '0; r = 0;
    case (o)
      0, 1: begin
        cc = (o == 1) ? c : 0;
        t = a + b + cc; r = t & 255;
        f[0] = t > 255;
        f[5] = ((a & 15) + (b & 15) + cc) > 15;
        sv = sgn8(a) + sgn8(b) + cc;
        f[3] = (sv > 127) || (sv < -128);
        we = 6'h3F;
      end
      2, 3, 8: begin
        x = (o == 8) ? 0 : a;
        y = (o == 8) ? a : b;
        cc = (o == 3) ? c : 0;
        t = x - y - cc; r = t & 255;
        f[0] = t < 0;
        f[5] = ((x & 15) - (y & 15) - cc) < 0;
        sv = sgn8(x) - sgn8(y) - cc;
        f[3] = (sv > 127) || (sv < -128);
        we = 6'h3F;
      end
      4: begin r = a & b; we = 6'b011110; end
      5: begin r = a | b; we = 6'b011110; end
      6: begin r = a ^ b; we = 6'b011110; end
      7: begin r = 255 - a; f[0] = 1'b1; we = 6'b011111; end
      9: begin r = (a + 1) & 255; f[3] = (sgn8(a) + 1) > 127; we = 6'b011110; end
      10: begin r = (a + 255) & 255; f[3] = (sgn8(a) - 1) < -128; we = 6'b011110; end
      11, 12, 13: begin
        r = a / 2;
        if (o == 12) r = r + 128 * c;
        if (o == 13) r = r + (a & 128);
        f[0] = (a % 2) != 0;
        f[3] = (r > 127) ^ f[0];
        we = 6'b011111;
      end
      default: begin r = (a % 16) * 16 + a / 16; we = '0; end
    endcase
    f[2] = r > 127;
    f[1] = (r == 0) && (o != 3 || z != 0);
    f[4] = f[2] ^ f[3];
    return {we, f & we, r[7:0]};
  endfunction

  task automatic do_byte(input int o, input int a, input int b, input int c, input int z);
    logic [19:0] e;
    in_valid = 1'b1; op = 5'(o); op_a = 8'(a); op_b = 8'(b);
    carry_in = c[0]; zero_in = z[0]; imm = '0;
    @(negedge clk);
    in_valid = 1'b0;
    e = model(o, a, b, c, z);
    check(out_valid === 1'b1, "R1 valid", {31'd0, out_valid}, 32'd1);
    check(result === e[7:0] && result_hi === 8'h00 && flag_we === e[19:14] &&
          (flags & flag_we) === e[13:8], req_of(o),
          {flag_we, flags & flag_we, result_hi, result}, {e[19:8], 8'h00, e[7:0]});
    if (flag_we[4])
      check(flags[4] === (flags[2] ^ flags[3]), "R9 sign", {31'd0, flags[4]}, {31'd0, flags[2] ^ flags[3]});
  endtask

  task automatic do_word(input bit sub, input int w, input int k, input bit distract);
    int s, sw, ev;
    logic [5:0] ef;
    in_valid = 1'b1; op = sub ? 5'd16 : 5'd15;
    op_a = 8'(w & 255); op_b = 8'(w / 256); imm = 6'(k);
    carry_in = 1'b0; zero_in = 1'b0;
    @(negedge clk);
    check(busy === 1'b1 && out_valid === 1'b0, "R10 busy", {30'd0, busy, out_valid}, 32'd2);
    if (distract) begin
      in_valid = 1'b1; op = 5'd0; op_a = 8'h5A; op_b = 8'hA5;
    end else in_valid = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    sw = (w > 32767) ? w - 65536 : w;
    ef = '0;
    if (sub) begin
      s = w - k; ef[0] = s < 0; ef[3] = (sw - k) < -32768;
    end else begin
      s = w + k; ef[0] = s > 65535; ef[3] = (sw + k) > 32767;
    end
    ev = s & 65535;
    ef[2] = ev > 32767;
    ef[1] = ev == 0;
    ef[4] = ef[2] ^ ef[3];
    check(out_valid === 1'b1 && busy === 1'b0 && {result_hi, result} === 16'(ev) &&
          flag_we === 6'b011111 && (flags & flag_we) === ef, distract ? "R11" : "R10",
          {out_valid, flag_we, flags & flag_we, result_hi, result}, {1'b1, 6'b011111, ef, 16'(ev)});
    if (distract) begin
      @(negedge clk);
      check(out_valid === 1'b0 && flag_we === 6'd0, "R11 no extra",
            {25'd0, out_valid, flag_we}, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int b;
    rst = 1'b1; in_valid = 1'b0; op = '0; op_a = '0; op_b = '0; imm = '0;
    carry_in = 1'b0; zero_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check(out_valid === 1'b0 && busy === 1'b0 && flag_we === 6'd0 && result === 8'd0 && result_hi === 8'd0,
          "R12 reset", {14'd0, out_valid, busy, flag_we, result_hi[1:0], result}, 32'd0);

    // two-operand byte operations: every op_a value against eight op_b patterns
    for (int o = 0; o <= 6; o++)
      for (int a = 0; a < 256; a++)
        for (int bi = 0; bi < 8; bi++) begin
          case (bi)
            0: b = 0;
            1: b = 255;
            2: b = 128;
            3: b = 127;
            4: b = 1;
            default: b = (a * 7 + bi * 29) & 255;
          endcase
          do_byte(o, a, b, (a >> bi) & 1, (a + bi) & 1);
        end

    // one-operand byte operations: every value with both carry-in states
    for (int o = 7; o <= 14; o++)
      for (int a = 0; a < 256; a++)
        for (int c = 0; c < 2; c++)
          do_byte(o, a, (a * 3) & 255, c, c);

    // R12 enables drop when idle
    @(negedge clk);
    check(out_valid === 1'b0 && flag_we === 6'd0, "R12 idle", {25'd0, out_valid, flag_we}, 32'd0);

    // word mode with boundary pairs and a spread of immediates
    for (int t = 0; t < 256; t++) begin
      int w;
      case (t % 8)
        0: w = 16'hFFFF;
        1: w = 16'h0000;
        2: w = 16'h7FFF;
        3: w = 16'h8000;
        default: w = (t * 4099 + 17) & 65535;
      endcase
      do_word(t[0], w, (t / 2) % 64, 1'b0);
    end

    // requests while busy are dropped
    do_word(1'b0, 16'h12FF, 1, 1'b1);
    do_word(1'b1, 16'h8000, 63, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule